// File: doc/BRIEF.md
# External Bus Cycle Controller

This block sequences each memory access on a multiplexed address/data bus. When a request (address plus a flag marking an instruction fetch) is accepted, the block decides whether the access is served by on-chip program memory or must run on the external bus. It then runs a fixed-length cycle: one address phase followed by `DATA_LEN` data phases.

For an external cycle it settles the data width from two configuration bits and, when configured for it, a width pin sampled at acceptance. It drives an address strobe and an instruction-fetch marker. The strobe works either as a short latch-enable pulse during the address phase or as an active-low address-valid signal that lasts the whole cycle.

A memory-select level is captured once after reset. While that level is high, the program window `0x2000`..`0x5FFF` maps on-chip. While it is low, every address goes off-chip.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: An accepted access goes on-chip (`sel_ext` = 0 for the whole cycle) only when the captured memory-select level is 1 and the address lies within 0x2000..0x5FFF inclusive. Every other access is external (`sel_ext` = 1). On-chip cycles report `width16` = 1.
- R2: After reset is released, the block is busy for one cycle, and `ext_access_pin` is captured on that cycle's rising edge. Later changes of the pin have no effect on routing until the next reset.
- R3: With `cfg_wide_en` = 1 and `cfg_narrow_en` = 1, an external cycle takes its width from `width_pin`: 0 gives 8 bits (`width16` = 0), and 1 gives 16 bits (`width16` = 1).
- R4: With `cfg_wide_en` = 0 and `cfg_narrow_en` = 1, every external cycle is 8-bit. With `cfg_wide_en` = 1 and `cfg_narrow_en` = 0, every external cycle is 16-bit. In both cases `width_pin` is ignored.
- R5: With both configuration bits at 0, the cycle reports `cfg_err` = 1 and `width16` = 1 for its whole duration. Any legal setting gives `cfg_err` = 0.
- R6: Width pin, configuration bits and strobe mode are sampled at the acceptance edge. Changing them during a cycle leaves that cycle's outputs unchanged.
- R7: With `cfg_strobe_mode` = 0 (latch pulse), `strobe` is 1 only during the address phase of an external cycle and 0 at all other times.
- R8: With `cfg_strobe_mode` = 1 (address valid), `strobe` is 0 during the address and data phases of an external cycle. It is 1 while idle and throughout on-chip cycles.
- R9: `inst_out` is 1 for the whole of an external cycle whose request had `req_fetch` = 1. It is 0 for on-chip fetches, data accesses and idle.
- R10: A request is accepted on a rising edge where `req_valid` = 1 and `busy` = 0. `busy` is then 1 for exactly 1 + `DATA_LEN` cycles, starting after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_addr | input | ADDR_W | Access address |
| req_fetch | input | 1 | Request is an instruction fetch |
| ext_access_pin | input | 1 | Memory-select level, captured after reset |
| cfg_wide_en | input | 1 | Configuration bit permitting 16-bit cycles |
| cfg_narrow_en | input | 1 | Configuration bit permitting 8-bit cycles |
| cfg_strobe_mode | input | 1 | 0 = latch pulse, 1 = active-low address valid |
| width_pin | input | 1 | Per-cycle width select (1 = 16-bit) |
| busy | output | 1 | Cycle (or post-reset capture) in progress |
| sel_ext | output | 1 | Current cycle runs on the external bus |
| strobe | output | 1 | Address strobe |
| inst_out | output | 1 | External instruction-fetch marker |
| width16 | output | 1 | Current cycle is 16-bit |
| cfg_err | output | 1 | Current cycle was accepted under an illegal configuration |

## Verification
The hardest case to reach from the ports is a change of the memory-select level that must be ignored. It has to happen after the capture cycle that follows reset, with no other route into the block. The bench holds the pin at one level through reset and flips it right after. It then sends window addresses that would route differently if the pin were still live, and finally repeats with a second reset at the opposite level. A second hard case is the hold of sampled inputs: the driver inverts the width pin, both configuration bits and the strobe mode on the cycle after every acceptance, and the monitor checks each phase against values predicted from the levels present at acceptance.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [1:0] {
    PH_INIT = 2'd0,
    PH_IDLE = 2'd1,
    PH_ADDR = 2'd2,
    PH_DATA = 2'd3
  } phase_t;

  typedef struct packed {
    logic ext;    // external bus cycle
    logic wide;   // 16-bit cycle
    logic fetch;  // instruction fetch
    logic adv;    // strobe in address-valid mode
    logic err;    // illegal width configuration
  } cyc_attr_t;

endpackage

// File: rtl/bcc_region_decode.sv
module bcc_region_decode #(
  parameter int unsigned       ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_LO = 'h2000,
  parameter logic [ADDR_W-1:0] WIN_HI = 'h5FFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_sel,
  output logic              onchip
);

  logic in_window;

  always_comb begin
    in_window = (addr >= WIN_LO) && (addr <= WIN_HI);
    onchip    = mem_sel && in_window;
  end

endmodule

// File: rtl/bcc_width_sel.sv
module bcc_width_sel (
  input  logic wide_en,
  input  logic narrow_en,
  input  logic pin,
  output logic wide,
  output logic illegal
);

  always_comb begin
    illegal = 1'b0;
    unique case ({wide_en, narrow_en})
      2'b11:   wide = pin;
      2'b10:   wide = 1'b1;
      2'b01:   wide = 1'b0;
      default: begin
        wide    = 1'b1;
        illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/bcc_strobe_gen.sv
module bcc_strobe_gen
  import bcc_pkg::*;
(
  input  phase_t    phase,
  input  cyc_attr_t attr,
  input  logic      live_mode,
  output logic      strobe,
  output logic      inst
);

  logic in_cycle;
  logic ext_active;
  logic mode_eff;

  always_comb begin
    in_cycle   = (phase == PH_ADDR) || (phase == PH_DATA);
    ext_active = in_cycle && attr.ext;
    mode_eff   = in_cycle ? attr.adv : live_mode;
    if (mode_eff) begin
      strobe = !ext_active;
    end else begin
      strobe = (phase == PH_ADDR) && attr.ext;
    end
    inst = ext_active && attr.fetch;
  end

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ONCHIP_LO = 'h2000,
  parameter logic [ADDR_W-1:0] ONCHIP_HI = 'h5FFF,
  parameter int unsigned       DATA_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_fetch,
  input  logic              ext_access_pin,
  input  logic              cfg_wide_en,
  input  logic              cfg_narrow_en,
  input  logic              cfg_strobe_mode,
  input  logic              width_pin,
  output logic              busy,
  output logic              sel_ext,
  output logic              strobe,
  output logic              inst_out,
  output logic              width16,
  output logic              cfg_err
);

  localparam int unsigned CNT_W = (DATA_LEN > 1) ? $clog2(DATA_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DATA_LEN - 1);

  phase_t          phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cyc_attr_t       attr_q, attr_new;
  logic            attr_en;
  logic            ea_q, ea_en;
  logic            onchip;
  logic            wide_sel, illegal;
  logic            in_cycle;

  bcc_region_decode #(
    .ADDR_W (ADDR_W),
    .WIN_LO (ONCHIP_LO),
    .WIN_HI (ONCHIP_HI)
  ) u_region (
    .addr    (req_addr),
    .mem_sel (ea_q),
    .onchip  (onchip)
  );

  bcc_width_sel u_width (
    .wide_en   (cfg_wide_en),
    .narrow_en (cfg_narrow_en),
    .pin       (width_pin),
    .wide      (wide_sel),
    .illegal   (illegal)
  );

  always_comb begin
    attr_new.ext   = !onchip;
    attr_new.wide  = onchip ? 1'b1 : wide_sel;
    attr_new.fetch = req_fetch;
    attr_new.adv   = cfg_strobe_mode;
    attr_new.err   = illegal;
  end

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    attr_en = 1'b0;
    ea_en   = 1'b0;
    unique case (phase_q)
      PH_INIT: begin
        ea_en   = 1'b1;
        phase_d = PH_IDLE;
      end
      PH_IDLE: begin
        if (req_valid) begin
          attr_en = 1'b1;
          phase_d = PH_ADDR;
        end
      end
      PH_ADDR: begin
        cnt_d   = CNT_LOAD;
        phase_d = PH_DATA;
      end
      PH_DATA: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INIT;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
    end else if (attr_en) begin
      attr_q <= attr_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q <= 1'b0;
    end else if (ea_en) begin
      ea_q <= ext_access_pin;
    end
  end

  bcc_strobe_gen u_strobe (
    .phase     (phase_q),
    .attr      (attr_q),
    .live_mode (cfg_strobe_mode),
    .strobe    (strobe),
    .inst      (inst_out)
  );

  always_comb begin
    in_cycle = (phase_q == PH_ADDR) || (phase_q == PH_DATA);
    busy     = (phase_q != PH_IDLE);
    sel_ext  = in_cycle && attr_q.ext;
    width16  = in_cycle && attr_q.wide;
    cfg_err  = in_cycle && attr_q.err;
  end

endmodule

// File: rtl/bus_cycle_ctrl_checker.sv
module bus_cycle_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic cfg_strobe_mode,
  input logic busy,
  input logic sel_ext,
  input logic strobe,
  input logic inst_out,
  input logic width16,
  input logic cfg_err
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  assert_ale_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_strobe_mode) |-> !strobe);

  assert_adv_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_strobe_mode) |-> strobe);

  assert_inst_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inst_out |-> sel_ext);

  assert_inst_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !inst_out);

  assert_err_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> width16);

  assert_width_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && busy && $past(busy)) |-> $stable(width16));

  assert_ext_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && busy && $past(busy)) |-> $stable(sel_ext));

endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_checker u_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .cfg_strobe_mode (cfg_strobe_mode),
  .busy            (busy),
  .sel_ext         (sel_ext),
  .strobe          (strobe),
  .inst_out        (inst_out),
  .width16         (width16),
  .cfg_err         (cfg_err)
);

// File: tb/bus_cycle_ctrl_test.sv
module bus_cycle_ctrl_test;

  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_LEN = 2;

  typedef struct {
    logic ext;
    logic wide;
    logic inst;
    logic adv;
    logic err;
  } exp_t;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_fetch;
  logic              ext_access_pin;
  logic              cfg_wide_en;
  logic              cfg_narrow_en;
  logic              cfg_strobe_mode;
  logic              width_pin;
  logic              busy, sel_ext, strobe, inst_out, width16, cfg_err;

  int   n_checks;
  int   n_fails;
  logic ea_model;
  exp_t exp_q[$];

  bus_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_LEN(DATA_LEN)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_addr        (req_addr),
    .req_fetch       (req_fetch),
    .ext_access_pin  (ext_access_pin),
    .cfg_wide_en     (cfg_wide_en),
    .cfg_narrow_en   (cfg_narrow_en),
    .cfg_strobe_mode (cfg_strobe_mode),
    .width_pin       (width_pin),
    .busy            (busy),
    .sel_ext         (sel_ext),
    .strobe          (strobe),
    .inst_out        (inst_out),
    .width16         (width16),
    .cfg_err         (cfg_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: computes the expected cycle from the requirements and queues it
  task automatic access(input logic [ADDR_W-1:0] addr, input logic fetch,
                        input logic we, input logic ne, input logic wpin,
                        input logic mode);
    exp_t e;
    logic on;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_addr        = addr;
    req_fetch       = fetch;
    cfg_wide_en     = we;
    cfg_narrow_en   = ne;
    width_pin       = wpin;
    cfg_strobe_mode = mode;
    req_valid       = 1'b1;
    on     = ea_model && (addr >= 16'h2000) && (addr <= 16'h5FFF);
    e.ext  = !on;
    e.err  = !we && !ne;
    if (on)         e.wide = 1'b1;
    else if (e.err) e.wide = 1'b1;
    else if (we && ne) e.wide = wpin;
    else            e.wide = we;
    e.inst = e.ext && fetch;
    e.adv  = mode;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid       = 1'b0;
    // R6: disturb every sampled input once the cycle is under way
    width_pin       = !wpin;
    cfg_wide_en     = !we;
    cfg_narrow_en   = !ne;
    cfg_strobe_mode = !mode;
  endtask

  // monitor: pops expected cycles and compares each phase
  initial begin
    logic prev_busy;
    logic tracking;
    int   ph;
    exp_t cur;
    prev_busy = 1'b1;
    tracking  = 1'b0;
    ph        = 0;
    forever begin
      @(negedge clk);
      #1;
      if (!rst_n) begin
        prev_busy = 1'b1;
        tracking  = 1'b0;
      end else begin
        if (busy && !prev_busy && exp_q.size() > 0) begin
          cur      = exp_q.pop_front();
          tracking = 1'b1;
          ph       = 0;
          chk("R1 sel_ext", sel_ext, cur.ext);
          chk("R3/R4/R5 width16", width16, cur.wide);
          chk("R5 cfg_err", cfg_err, cur.err);
          chk("R9 inst_out", inst_out, cur.inst);
          if (cur.adv) chk("R8 strobe addr", strobe, !cur.ext);
          else         chk("R7 strobe addr", strobe, cur.ext);
        end else if (busy && tracking) begin
          ph++;
          chk("R6 sel_ext hold", sel_ext, cur.ext);
          chk("R6 width16 hold", width16, cur.wide);
          chk("R6 cfg_err hold", cfg_err, cur.err);
          chk("R9 inst_out data", inst_out, cur.inst);
          if (cur.adv) chk("R8 strobe data", strobe, !cur.ext);
          else         chk("R7 strobe data", strobe, 1'b0);
        end else if (!busy && prev_busy && tracking) begin
          tracking = 1'b0;
          chk("R10 cycle length", ph, DATA_LEN);
          chk("R9 inst idle", inst_out, 1'b0);
          chk("R7/R8 strobe idle", strobe, cfg_strobe_mode);
        end
        prev_busy = busy;
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  task automatic do_reset(input logic ea);
    rst_n          = 1'b0;
    ext_access_pin = ea;
    ea_model       = ea;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 busy in reset", busy, 1'b1);
    chk("R1 sel_ext in reset", sel_ext, 1'b0);
    chk("R9 inst in reset", inst_out, 1'b0);
    chk("R5 cfg_err in reset", cfg_err, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R2 busy during capture", busy, 1'b1);
    @(negedge clk);
    #1;
    chk("R2 idle after capture", busy, 1'b0);
    ext_access_pin = !ea;  // R2: must be ignored from now on
  endtask

  initial begin
    n_checks        = 0;
    n_fails         = 0;
    req_valid       = 1'b0;
    req_addr        = '0;
    req_fetch       = 1'b0;
    cfg_wide_en     = 1'b1;
    cfg_narrow_en   = 1'b1;
    cfg_strobe_mode = 1'b0;
    width_pin       = 1'b0;
    do_reset(1'b1);
    chk("R7 strobe idle ALE", strobe, 1'b0);

    access(16'h3000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R1 R2 on-chip fetch
    access(16'h8000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R3 8-bit, R7 pulse, R9
    access(16'h8000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1); // R3 16-bit, R8
    access(16'h1FFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1); // R4 forced 8, below window
    access(16'h5FFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R1 top of window
    access(16'h6000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R4 forced 16, above window
    access(16'h2000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1); // R8 on-chip stays high
    access(16'h9000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R5 illegal external
    access(16'h4000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); // R5 illegal on-chip
    access(16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1); // R4 pin ignored

    while (exp_q.size() > 0 || busy) @(negedge clk);
    repeat (2) @(negedge clk);

    do_reset(1'b0);
    access(16'h3000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // R1 R2 window goes off-chip
    access(16'h2000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);

    while (exp_q.size() > 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule